// File: doc/BRIEF.md
# Multi-Lane Symbol Compare Checker

This block is a built-in self-test receiver for a serial link of many lanes. It holds a four-slot expected pattern. Each slot is an 8-bit byte taken from the `pat_bytes` configuration input, plus a type-select bit that marks the slot as a control character (1) or a data character (0). While `chk_en` is high, a slot index steps through slots 0, 1, 2, 3, 0, ... one step per clock. In every enabled cycle, the 9-bit symbol received on each lane is compared with the symbol of the current slot. All lanes use the same slot.

When any lane mismatches, the block raises `err_pulse` for one cycle. Outside counters can accumulate it to get an error rate. The first mismatch is also latched into a status record: the raw 9-bit symbol from the failing lane, that lane's index cut to 5 bits, and a sticky flag. The record stays until software writes a 1 to clear it. A warm reset does not disturb the record; only the cold (power-on) reset clears it.

The slot sequencer has two states. `SEQ_IDLE` holds slot 0 and moves to `SEQ_RUN` when enable rises (transition *start*). `SEQ_RUN` advances the slot each cycle (transition *step*) and returns to `SEQ_IDLE` when enable falls (transition *halt*).

The error logger also has two states. `LOG_EMPTY` moves to `LOG_HELD` on a mismatch and captures it (transition *capture*). In `LOG_HELD`, a clear write returns the logger to `LOG_EMPTY` (transition *release*). If a mismatch arrives in the same cycle as the clear write, the logger stays in `LOG_HELD` and captures the new mismatch (transition *recapture*).

Top module: `symchk_top`

## Requirements
- R1: The type-select register `type_sel` resets to 4'b0101 on either reset (bit k belongs to slot k, so slots 0 and 2 are control and slots 1 and 3 are data). A cycle with `cfg_type_we` high loads `cfg_type_wdata` into it at the next edge.
- R2: The expected symbol for slot k is {type_sel[k], pat_bytes[8k+7:8k]}. Lane n's received symbol is `rx_syms[9n+8:9n]`, where bit 8 is the control flag. A difference in any bit, including only the control flag, is a mismatch.
- R3: While enabled, the slot index advances by one per cycle and wraps from 3 to 0. Every lane is compared with the same slot in a given cycle.
- R4: While `chk_en` is low, no mismatch is reported and the slot index returns to 0. The first enabled cycle after that compares slot 0.
- R5: `err_pulse` is high in the cycle after every enabled cycle that has at least one mismatching lane, and low after every other cycle.
- R6: When a mismatch occurs and the flag is clear, the next edge sets `err_flag` and stores the raw received symbol of the reported lane in `err_value` and that lane's index in `err_lane`.
- R7: When several lanes mismatch in the same cycle, the lowest-numbered lane is the one captured.
- R8: `err_lane` holds the lane index modulo 32.
- R9: While `err_flag` is set and no clear is written, later mismatches leave `err_flag`, `err_value` and `err_lane` unchanged.
- R10: A cycle with `stat_clr_we` high and `stat_clr_wdata` = 1 clears `err_flag`. With `stat_clr_wdata` = 0 the write has no effect.
- R11: `warm_rst_n` resets the slot index, `type_sel` and `err_pulse` but leaves `err_flag`, `err_value` and `err_lane` intact. `cold_rst_n` clears everything.
- R12: A clear write and a mismatch in the same cycle leave `err_flag` set, and the new mismatch is captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Symbol clock |
| cold_rst_n | input | 1 | Power-on reset, active low, clears everything |
| warm_rst_n | input | 1 | Warm reset, active low, spares the error record |
| chk_en | input | 1 | Enables comparison and slot stepping |
| cfg_type_we | input | 1 | Write strobe for the type selects |
| cfg_type_wdata | input | 4 | New type selects, bit k for slot k |
| pat_bytes | input | 32 | Pattern bytes, byte k for slot k |
| rx_syms | input | NLANES*9 | Received symbols, 9 bits per lane |
| stat_clr_we | input | 1 | Write strobe for the error flag |
| stat_clr_wdata | input | 1 | A 1 clears the flag; a 0 does nothing |
| type_sel | output | 4 | Current type selects |
| err_pulse | output | 1 | One-cycle pulse per mismatching cycle |
| err_flag | output | 1 | Sticky error-detected flag |
| err_value | output | 9 | Raw symbol from the captured lane |
| err_lane | output | 5 | Captured lane index modulo 32 |

## Verification
The assertions check these behaviours on every cycle:
- the slot index steps and wraps, and returns to zero when idle;
- a mismatch always produces a pulse;
- the first capture is stored into the record;
- a held record stays fixed while no clear is written;
- a write of zero leaves the flag set;
- no pulse appears while disabled.

Only the bench scenarios can show the remaining behaviours:
- which lane wins when several fail in the same cycle;
- aliasing of lane indices above 31;
- that type selects change the expected symbol;
- a mismatch on the control flag alone;
- the different reach of the warm and cold resets.

// File: rtl/symchk_pkg.sv
package symchk_pkg;
    localparam int NSLOT  = 4;
    localparam int SLOT_W = $clog2(NSLOT);
    localparam int BYTE_W = 8;
    localparam int SYM_W  = BYTE_W + 1;
    localparam int LANE_W = 5;
    localparam logic [NSLOT-1:0] TYPE_RST = 4'b0101;

    typedef struct packed {
        logic              ctl;
        logic [BYTE_W-1:0] data;
    } sym_t;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_e;

    typedef enum logic {
        LOG_EMPTY = 1'b0,
        LOG_HELD  = 1'b1
    } log_state_e;
endpackage

// File: rtl/symchk_seq.sv
module symchk_seq
    import symchk_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en,
    input  logic                    cfg_we,
    input  logic [NSLOT-1:0]        cfg_wdata,
    input  logic [NSLOT*BYTE_W-1:0] pat_bytes,
    output logic [NSLOT-1:0]        type_sel,
    output sym_t                    exp_sym
);
    seq_state_e        state, state_nx;
    logic [SLOT_W-1:0] slot, slot_nx;
    logic [BYTE_W-1:0] pat_arr [NSLOT];

    for (genvar k = 0; k < NSLOT; k++) begin : g_slot
        assign pat_arr[k] = pat_bytes[k*BYTE_W +: BYTE_W];
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= SEQ_IDLE;
            slot  <= '0;
        end else begin
            state <= state_nx;
            slot  <= slot_nx;
        end
    end

    // next state and slot
    always_comb begin
        state_nx = state;
        slot_nx  = slot;
        unique case (state)
            SEQ_IDLE: begin
                slot_nx = '0;
                if (en) begin
                    state_nx = SEQ_RUN;
                    slot_nx  = slot + 1'b1;
                end
            end
            SEQ_RUN: begin
                if (en) begin
                    slot_nx = slot + 1'b1;
                end else begin
                    state_nx = SEQ_IDLE;
                    slot_nx  = '0;
                end
            end
            default: begin
                state_nx = SEQ_IDLE;
                slot_nx  = '0;
            end
        endcase
    end

    // type select register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      type_sel <= TYPE_RST;
        else if (cfg_we) type_sel <= cfg_wdata;
    end

    // expected symbol of current slot
    always_comb begin
        exp_sym.ctl  = type_sel[slot];
        exp_sym.data = pat_arr[slot];
    end

    assert_slot_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (slot == '0));

    assert_slot_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> (slot == SLOT_W'($past(slot) + 1'b1)));
endmodule

// File: rtl/symchk_cmp.sv
module symchk_cmp
    import symchk_pkg::*;
#(
    parameter int NLANES = 8
) (
    input  logic                    en,
    input  sym_t                    exp_sym,
    input  logic [NLANES*SYM_W-1:0] rx_syms,
    output logic                    hit,
    output logic [LANE_W-1:0]       hit_lane,
    output logic [SYM_W-1:0]        hit_val
);
    logic [SYM_W-1:0]  lane_sym [NLANES];
    logic [NLANES-1:0] mism;

    for (genvar n = 0; n < NLANES; n++) begin : g_lane
        assign lane_sym[n] = rx_syms[n*SYM_W +: SYM_W];
        assign mism[n]     = en && (lane_sym[n] != exp_sym);
    end

    assign hit = |mism;

    // lowest failing lane wins; index truncation aliases modulo 32
    always_comb begin
        hit_lane = '0;
        hit_val  = '0;
        for (int l = NLANES - 1; l >= 0; l--) begin
            if (mism[l]) begin
                hit_lane = l[LANE_W-1:0];
                hit_val  = lane_sym[l];
            end
        end
    end
endmodule

// File: rtl/symchk_log.sv
module symchk_log
    import symchk_pkg::*;
(
    input  logic              clk,
    input  logic              cold_rst_n,
    input  logic              pulse_rst_n,
    input  logic              hit,
    input  logic [LANE_W-1:0] hit_lane,
    input  logic [SYM_W-1:0]  hit_val,
    input  logic              clr_we,
    input  logic              clr_wdata,
    output logic              err_pulse,
    output logic              err_flag,
    output logic [SYM_W-1:0]  err_value,
    output logic [LANE_W-1:0] err_lane
);
    log_state_e state, state_nx;
    logic       clr, capture;

    assign clr = clr_we && clr_wdata;

    // state register, survives warm reset
    always_ff @(posedge clk or negedge cold_rst_n) begin
        if (!cold_rst_n) state <= LOG_EMPTY;
        else             state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        capture  = 1'b0;
        unique case (state)
            LOG_EMPTY: begin
                if (hit) begin
                    state_nx = LOG_HELD;
                    capture  = 1'b1;
                end
            end
            LOG_HELD: begin
                if (clr) begin
                    if (hit) capture = 1'b1;
                    else     state_nx = LOG_EMPTY;
                end
            end
            default: state_nx = LOG_EMPTY;
        endcase
    end

    // captured fields
    always_ff @(posedge clk or negedge cold_rst_n) begin
        if (!cold_rst_n) begin
            err_value <= '0;
            err_lane  <= '0;
        end else if (capture) begin
            err_value <= hit_val;
            err_lane  <= hit_lane;
        end
    end

    // error pulse, cleared by any reset
    always_ff @(posedge clk or negedge pulse_rst_n) begin
        if (!pulse_rst_n) err_pulse <= 1'b0;
        else              err_pulse <= hit;
    end

    assign err_flag = (state == LOG_HELD);

    assert_pulse_R5: assert property (@(posedge clk) disable iff (!cold_rst_n || !pulse_rst_n)
        hit |=> err_pulse);

    assert_capture_R6: assert property (@(posedge clk) disable iff (!cold_rst_n)
        (hit && !err_flag) |=> (err_flag && err_lane == $past(hit_lane) && err_value == $past(hit_val)));

    assert_hold_first_R9: assert property (@(posedge clk) disable iff (!cold_rst_n)
        (err_flag && !clr_we) |=> (err_flag && $stable(err_value) && $stable(err_lane)));

    assert_clr_zero_R10: assert property (@(posedge clk) disable iff (!cold_rst_n)
        (err_flag && clr_we && !clr_wdata) |=> err_flag);
endmodule

// File: rtl/symchk_top.sv
module symchk_top
    import symchk_pkg::*;
#(
    parameter int NLANES = 8
) (
    input  logic                    clk,
    input  logic                    cold_rst_n,
    input  logic                    warm_rst_n,
    input  logic                    chk_en,
    input  logic                    cfg_type_we,
    input  logic [NSLOT-1:0]        cfg_type_wdata,
    input  logic [NSLOT*BYTE_W-1:0] pat_bytes,
    input  logic [NLANES*SYM_W-1:0] rx_syms,
    input  logic                    stat_clr_we,
    input  logic                    stat_clr_wdata,
    output logic [NSLOT-1:0]        type_sel,
    output logic                    err_pulse,
    output logic                    err_flag,
    output logic [SYM_W-1:0]        err_value,
    output logic [LANE_W-1:0]       err_lane
);
    logic              rst_any_n;
    sym_t              exp_sym;
    logic              hit;
    logic [LANE_W-1:0] hit_lane;
    logic [SYM_W-1:0]  hit_val;

    assign rst_any_n = cold_rst_n && warm_rst_n;

    symchk_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_any_n),
        .en        (chk_en),
        .cfg_we    (cfg_type_we),
        .cfg_wdata (cfg_type_wdata),
        .pat_bytes (pat_bytes),
        .type_sel  (type_sel),
        .exp_sym   (exp_sym)
    );

    symchk_cmp #(.NLANES(NLANES)) u_cmp (
        .en       (chk_en),
        .exp_sym  (exp_sym),
        .rx_syms  (rx_syms),
        .hit      (hit),
        .hit_lane (hit_lane),
        .hit_val  (hit_val)
    );

    symchk_log u_log (
        .clk         (clk),
        .cold_rst_n  (cold_rst_n),
        .pulse_rst_n (rst_any_n),
        .hit         (hit),
        .hit_lane    (hit_lane),
        .hit_val     (hit_val),
        .clr_we      (stat_clr_we),
        .clr_wdata   (stat_clr_wdata),
        .err_pulse   (err_pulse),
        .err_flag    (err_flag),
        .err_value   (err_value),
        .err_lane    (err_lane)
    );

    assert_quiet_idle_R4: assert property (@(posedge clk) disable iff (!rst_any_n)
        !chk_en |=> !err_pulse);

    assert_pulse_flag_R6: assert property (@(posedge clk) disable iff (!cold_rst_n)
        err_pulse |-> err_flag);
endmodule

// File: tb/symchk_top_test.sv
module symchk_top_test;
    localparam int NL = 34;

    typedef struct {
        logic       pulse;
        logic       flag;
        logic [8:0] val;
        logic [4:0] lane;
        logic [3:0] tsel;
        string      tag;
    } item_t;

    logic          clk = 1'b0;
    logic          cold_rst_n = 1'b0, warm_rst_n = 1'b0;
    logic          chk_en = 1'b0, cfg_type_we = 1'b0, stat_clr_we = 1'b0, stat_clr_wdata = 1'b0;
    logic [3:0]    cfg_type_wdata = '0;
    logic [31:0]   pat_bytes = 32'hBC4A1CF7;
    logic [NL*9-1:0] rx_syms = '0;
    logic [3:0]    type_sel;
    logic          err_pulse, err_flag;
    logic [8:0]    err_value;
    logic [4:0]    err_lane;

    int checks = 0, fails = 0;
    item_t q[$];
    item_t cur;

    // bench model
    logic [3:0] mtype = 4'b0101;
    int         mslot = 0;
    logic       mflag = 0, mpulse = 0;
    logic [8:0] mval = 0;
    logic [4:0] mlane = 0;

    always #4 clk = ~clk;

    symchk_top #(.NLANES(NL)) uut (
        .clk(clk), .cold_rst_n(cold_rst_n), .warm_rst_n(warm_rst_n), .chk_en(chk_en),
        .cfg_type_we(cfg_type_we), .cfg_type_wdata(cfg_type_wdata), .pat_bytes(pat_bytes),
        .rx_syms(rx_syms), .stat_clr_we(stat_clr_we), .stat_clr_wdata(stat_clr_wdata),
        .type_sel(type_sel), .err_pulse(err_pulse), .err_flag(err_flag),
        .err_value(err_value), .err_lane(err_lane)
    );

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    task automatic direct(string tag);
        checks++;
        if (err_pulse !== mpulse || err_flag !== mflag || err_value !== mval ||
            err_lane !== mlane || type_sel !== mtype) begin
            fails++;
            $display("FAIL %s: got pulse=%0b flag=%0b val=%h lane=%0d tsel=%b exp pulse=%0b flag=%0b val=%h lane=%0d tsel=%b",
                     tag, err_pulse, err_flag, err_value, err_lane, type_sel,
                     mpulse, mflag, mval, mlane, mtype);
        end
    endtask

    // driver: one symbol time of stimulus, expected result pushed to scoreboard
    task automatic step(bit e, int la, int lb, logic [8:0] mask, bit cw, bit cd, int cfg, string tag);
        logic [8:0] ex;
        logic       hit;
        int         low;
        item_t      it;
        @(negedge clk);
        ex = {mtype[mslot], pat_bytes[mslot*8 +: 8]};
        for (int l = 0; l < NL; l++) rx_syms[l*9 +: 9] = ex;
        if (la >= 0) rx_syms[la*9 +: 9] = ex ^ mask;
        if (lb >= 0) rx_syms[lb*9 +: 9] = ex ^ 9'h100;
        chk_en = e;
        stat_clr_we = cw;
        stat_clr_wdata = cd;
        cfg_type_we = (cfg >= 0);
        cfg_type_wdata = (cfg >= 0) ? cfg[3:0] : 4'h0;
        hit = e && (la >= 0 || lb >= 0);
        low = (la < 0) ? lb : ((lb < 0 || la < lb) ? la : lb);
        mpulse = hit;
        if (mflag && cw && cd) mflag = 0;
        if (!mflag && hit) begin
            mflag = 1;
            mlane = low[4:0];
            mval  = (low == la) ? (ex ^ mask) : (ex ^ 9'h100);
        end
        mslot = e ? (mslot + 1) % 4 : 0;
        if (cfg >= 0) mtype = cfg[3:0];
        it.pulse = mpulse; it.flag = mflag; it.val = mval;
        it.lane = mlane; it.tsel = mtype; it.tag = tag;
        q.push_back(it);
    endtask

    // monitor: compare after each active edge
    always @(posedge clk) begin
        #2;
        if (q.size() > 0) begin
            cur = q.pop_front();
            checks++;
            if (err_pulse !== cur.pulse || err_flag !== cur.flag || err_value !== cur.val ||
                err_lane !== cur.lane || type_sel !== cur.tsel) begin
                fails++;
                $display("FAIL %s: got pulse=%0b flag=%0b val=%h lane=%0d tsel=%b exp pulse=%0b flag=%0b val=%h lane=%0d tsel=%b",
                         cur.tag, err_pulse, err_flag, err_value, err_lane, type_sel,
                         cur.pulse, cur.flag, cur.val, cur.lane, cur.tsel);
            end
        end
    end

    initial begin
        #(8 * 20000);
        fails++;
        $display("FAIL watchdog: run did not finish");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        cold_rst_n = 1'b1;
        warm_rst_n = 1'b1;
        #1 direct("R1 reset state");

        for (int i = 0; i < 8; i++) step(1, -1, -1, 9'h0, 0, 0, -1, "R3 clean wrapping run");
        step(0, 4, -1, 9'h0FF, 0, 0, -1, "R4 idle ignores mismatch");
        step(0, 4, -1, 9'h0FF, 0, 0, -1, "R4 idle ignores mismatch");
        step(1, 5, -1, 9'h001, 0, 0, -1, "R6 first capture at slot 0");
        step(1, 2, -1, 9'h0F0, 0, 0, -1, "R9 later error keeps first, R5 pulse");
        step(0, -1, -1, 9'h0, 1, 0, -1, "R10 write zero no effect");
        step(0, -1, -1, 9'h0, 1, 1, -1, "R10 write one clears");
        step(1, 7, 3, 9'h010, 0, 0, -1, "R7 lowest lane captured");
        step(1, -1, -1, 9'h0, 0, 0, -1, "R5 clean cycle no pulse");
        step(1, 9, -1, 9'h003, 1, 1, -1, "R12 clear with error recaptures");
        step(0, -1, -1, 9'h0, 1, 1, -1, "R10 clear");
        step(1, 33, -1, 9'h080, 0, 0, -1, "R8 lane 33 aliases to 1");
        step(0, -1, -1, 9'h0, 1, 1, -1, "R10 clear");
        step(0, -1, -1, 9'h0, 0, 0, 10, "R1 type select write");
        for (int i = 0; i < 4; i++) step(1, -1, -1, 9'h0, 0, 0, -1, "R2 expected follows type selects");
        step(1, 6, -1, 9'h100, 0, 0, -1, "R2 control flag only mismatch");
        step(0, -1, -1, 9'h0, 0, 0, -1, "R4 idle");

        @(negedge clk);
        warm_rst_n = 1'b0;
        repeat (2) @(negedge clk);
        warm_rst_n = 1'b1;
        mtype = 4'b0101; mslot = 0; mpulse = 0;
        #1 direct("R11 warm reset keeps record");
        for (int i = 0; i < 4; i++) step(1, -1, -1, 9'h0, 0, 0, -1, "R11 run after warm reset");

        @(negedge clk);
        chk_en = 1'b0;
        cold_rst_n = 1'b0;
        repeat (2) @(negedge clk);
        cold_rst_n = 1'b1;
        mtype = 4'b0101; mslot = 0; mpulse = 0; mflag = 0; mval = 0; mlane = 0;
        #1 direct("R11 cold reset clears record");
        step(1, 0, -1, 9'h1FF, 0, 0, -1, "R6 lane 0 capture after cold reset");
        step(0, -1, -1, 9'h0, 0, 0, -1, "R5 pulse drops");

        repeat (3) @(negedge clk);
        summary();
        $finish;
    end
endmodule